// File: doc/BRIEF.md
# Limited-Range Pixel Clamp

This block sits on a 12-bit-per-channel RGB pixel stream and forces each channel into a legal video range before the pixels leave the display pipe. A 3-bit format code picks the range. Codes for 8, 10 and 12 bits per channel apply the usual limited range (nominal 16..235 at 8 bits) scaled onto the 12-bit bus. A separate code applies lower and upper bounds that are held per channel and can be loaded. Codes with no clamp meaning, and any pixel presented while the enable is low, pass through unchanged.

The programmable bounds live in registers inside the block. They come out of reset with safe defaults and are replaced as a set whenever the load strobe is high. Every output is registered, so pixels appear one cycle after they are accepted, and output valid follows input valid.

Top module: `pix_range_clamp`

## Requirements
- R1: In the first cycle after synchronous reset, o_valid is 0 and o_r, o_g and o_b are 0.
- R2: o_valid in a cycle equals i_valid of the previous cycle, and the pixel accepted with i_valid appears on the outputs in the next cycle.
- R3: With clamp_en at 0, every channel is output unchanged, whatever the value of fmt_code.
- R4: With clamp_en at 1, fmt_code 0 (6 bpc) and the unused codes 4, 5 and 6 pass every channel unchanged.
- R5: With clamp_en at 1 and fmt_code 1, 2 or 3 (8, 10 or 12 bpc), each channel is limited to the range 0x100..0xEB0.
- R6: With clamp_en at 1 and fmt_code 7, channel R is limited by its own programmable bounds, and channels G and B are limited by theirs.
- R7: After reset, every channel's programmable lower bound is 0x010 and its upper bound is 0xFEF.
- R8: When bnd_wr is 1 at a clock edge, all six bound inputs are stored at that edge, and they apply to every pixel accepted after it.
- R9: Each channel is compared on its own. A value below the lower bound gives the lower bound, a value above the upper bound gives the upper bound, and a value inside the range is unchanged.
- R10: While i_valid is 0, o_r, o_g and o_b hold the last clamped pixel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| i_valid | input | 1 | Input pixel valid |
| i_r | input | 12 | Red channel in |
| i_g | input | 12 | Green channel in |
| i_b | input | 12 | Blue channel in |
| clamp_en | input | 1 | Limited-range request; when low, all data passes through |
| fmt_code | input | 3 | Range select: 0 means 6 bpc with no clamp, 1/2/3 mean 8/10/12 bpc, 7 means programmable, 4-6 are unused |
| bnd_wr | input | 1 | Load strobe for the six programmable bounds |
| lo_r | input | 12 | Red lower bound to load |
| hi_r | input | 12 | Red upper bound to load |
| lo_g | input | 12 | Green lower bound to load |
| hi_g | input | 12 | Green upper bound to load |
| lo_b | input | 12 | Blue lower bound to load |
| hi_b | input | 12 | Blue upper bound to load |
| o_valid | output | 1 | Output pixel valid |
| o_r | output | 12 | Red channel out |
| o_g | output | 12 | Green channel out |
| o_b | output | 12 | Blue channel out |

## Verification
The range assertions rely on each loaded lower bound being no greater than its upper bound. The stimulus loads only ordered pairs, some of them narrow. The assertions also rely on clamp_en, fmt_code and the bounds staying steady through the cycle in which a pixel is accepted. The stimulus changes these only at the falling edge, together with the pixel they belong to. Every input value is swept in coarse steps, with extra points placed on and next to each bound, and R, G and B get different values so that the channels are seen to act on their own.

// File: rtl/pclamp_pkg.sv
package pclamp_pkg;

    localparam int unsigned PIX_W = 12;
    localparam int unsigned NCH   = 3;

    typedef logic [PIX_W-1:0] chan_t;

    typedef struct packed {
        chan_t lo;
        chan_t hi;
    } lim_t;

    // Format code values
    localparam logic [2:0] FC_NONE  = 3'd0;
    localparam logic [2:0] FC_D8    = 3'd1;
    localparam logic [2:0] FC_D10   = 3'd2;
    localparam logic [2:0] FC_D12   = 3'd3;
    localparam logic [2:0] FC_PROG  = 3'd7;

    localparam chan_t PROG_LO_RST = chan_t'(16);
    localparam chan_t PROG_HI_RST = chan_t'(4079);

    // Limited range of a given output depth, left-aligned on the bus
    function automatic lim_t depth_limits(input int unsigned depth);
        lim_t l;
        int unsigned up;
        int unsigned lo_n;
        int unsigned hi_n;
        up   = depth - 8;
        lo_n = 16  << up;
        hi_n = 235 << up;
        l.lo = chan_t'(lo_n << (PIX_W - depth));
        l.hi = chan_t'(hi_n << (PIX_W - depth));
        return l;
    endfunction

    function automatic chan_t clamp_one(input chan_t v, input lim_t l);
        if (v < l.lo)      return l.lo;
        else if (v > l.hi) return l.hi;
        else               return v;
    endfunction

endpackage

// File: rtl/pclamp_bounds.sv
module pclamp_bounds
    import pclamp_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                wr,
    input  lim_t [NCH-1:0]      lim_in,
    output lim_t [NCH-1:0]      lim_q
);

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        always_ff @(posedge clk) begin
            if (rst) begin
                lim_q[c].lo <= PROG_LO_RST;
                lim_q[c].hi <= PROG_HI_RST;
            end else if (wr) begin
                lim_q[c] <= lim_in[c];
            end
        end

        // R7: defaults present right after reset
        a_r7_reset_default: assert property (@(posedge clk)
            rst |=> (lim_q[c].lo == PROG_LO_RST && lim_q[c].hi == PROG_HI_RST));

        // R8: a load stores the presented bounds
        a_r8_load: assert property (@(posedge clk) disable iff (rst)
            wr |=> (lim_q[c] == $past(lim_in[c])));

        // R8: without a load the bounds do not move
        a_r8_hold: assert property (@(posedge clk) disable iff (rst)
            !wr |=> $stable(lim_q[c]));
    end

endmodule

// File: rtl/pclamp_select.sv
module pclamp_select
    import pclamp_pkg::*;
(
    input  logic                en,
    input  logic [2:0]          code,
    input  lim_t [NCH-1:0]      prog,
    output logic                act,
    output lim_t [NCH-1:0]      lim_sel
);

    localparam lim_t L8  = depth_limits(8);
    localparam lim_t L10 = depth_limits(10);
    localparam lim_t L12 = depth_limits(12);

    always_comb begin
        act = 1'b0;
        for (int c = 0; c < NCH; c++) begin
            lim_sel[c].lo = '0;
            lim_sel[c].hi = '1;
        end
        if (en) begin
            unique case (code)
                FC_D8: begin
                    act = 1'b1;
                    for (int c = 0; c < NCH; c++) lim_sel[c] = L8;
                end
                FC_D10: begin
                    act = 1'b1;
                    for (int c = 0; c < NCH; c++) lim_sel[c] = L10;
                end
                FC_D12: begin
                    act = 1'b1;
                    for (int c = 0; c < NCH; c++) lim_sel[c] = L12;
                end
                FC_PROG: begin
                    act     = 1'b1;
                    lim_sel = prog;
                end
                default: act = 1'b0;
            endcase
        end
    end

endmodule

// File: rtl/pclamp_lane.sv
module pclamp_lane
    import pclamp_pkg::*;
(
    input  logic   act,
    input  lim_t   lim,
    input  chan_t  din,
    output chan_t  dout
);

    assign dout = act ? clamp_one(din, lim) : din;

endmodule

// File: rtl/pix_range_clamp.sv
module pix_range_clamp
    import pclamp_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                i_valid,
    input  logic [PIX_W-1:0]    i_r,
    input  logic [PIX_W-1:0]    i_g,
    input  logic [PIX_W-1:0]    i_b,
    input  logic                clamp_en,
    input  logic [2:0]          fmt_code,
    input  logic                bnd_wr,
    input  logic [PIX_W-1:0]    lo_r,
    input  logic [PIX_W-1:0]    hi_r,
    input  logic [PIX_W-1:0]    lo_g,
    input  logic [PIX_W-1:0]    hi_g,
    input  logic [PIX_W-1:0]    lo_b,
    input  logic [PIX_W-1:0]    hi_b,
    output logic                o_valid,
    output logic [PIX_W-1:0]    o_r,
    output logic [PIX_W-1:0]    o_g,
    output logic [PIX_W-1:0]    o_b
);

    localparam lim_t FIX = depth_limits(8);

    lim_t [NCH-1:0]  bnd_in;
    lim_t [NCH-1:0]  bnd_q;
    lim_t [NCH-1:0]  lim_sel;
    chan_t [NCH-1:0] din;
    chan_t [NCH-1:0] dcl;
    chan_t [NCH-1:0] dq;
    logic            act;

    assign bnd_in[0] = '{lo: lo_r, hi: hi_r};
    assign bnd_in[1] = '{lo: lo_g, hi: hi_g};
    assign bnd_in[2] = '{lo: lo_b, hi: hi_b};
    assign din[0] = i_r;
    assign din[1] = i_g;
    assign din[2] = i_b;

    pclamp_bounds u_bounds (
        .clk    (clk),
        .rst    (rst),
        .wr     (bnd_wr),
        .lim_in (bnd_in),
        .lim_q  (bnd_q)
    );

    pclamp_select u_sel (
        .en      (clamp_en),
        .code    (fmt_code),
        .prog    (bnd_q),
        .act     (act),
        .lim_sel (lim_sel)
    );

    for (genvar c = 0; c < NCH; c++) begin : g_lane
        pclamp_lane u_lane (
            .act  (act),
            .lim  (lim_sel[c]),
            .din  (din[c]),
            .dout (dcl[c])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            o_valid <= 1'b0;
            dq      <= '0;
        end else begin
            o_valid <= i_valid;
            if (i_valid) dq <= dcl;
        end
    end

    assign o_r = dq[0];
    assign o_g = dq[1];
    assign o_b = dq[2];

    // R1: cleared outputs after reset
    a_r1_reset_clear: assert property (@(posedge clk)
        rst |=> (!o_valid && o_r == '0 && o_g == '0 && o_b == '0));

    // R2: valid delayed by one cycle
    a_r2_valid_rise: assert property (@(posedge clk) disable iff (rst)
        i_valid |=> o_valid);
    a_r2_valid_low: assert property (@(posedge clk) disable iff (rst)
        !i_valid |=> !o_valid);

    // R3: enable low is a plain delay
    a_r3_bypass: assert property (@(posedge clk) disable iff (rst)
        (i_valid && !clamp_en) |=>
            (o_r == $past(i_r) && o_g == $past(i_g) && o_b == $past(i_b)));

    // R4: codes without a clamp meaning pass through
    a_r4_no_clamp_codes: assert property (@(posedge clk) disable iff (rst)
        (i_valid && clamp_en && (fmt_code == 3'd0 || fmt_code == 3'd4 ||
                                 fmt_code == 3'd5 || fmt_code == 3'd6)) |=>
            (o_r == $past(i_r) && o_g == $past(i_g) && o_b == $past(i_b)));

    // R5: fixed limited range holds on every channel
    a_r5_fixed_range: assert property (@(posedge clk) disable iff (rst)
        (i_valid && clamp_en && (fmt_code == 3'd1 || fmt_code == 3'd2 || fmt_code == 3'd3)) |=>
            (o_r >= FIX.lo && o_r <= FIX.hi && o_g >= FIX.lo && o_g <= FIX.hi &&
             o_b >= FIX.lo && o_b <= FIX.hi));

    // R9: in-range values are untouched
    a_r9_inside_kept: assert property (@(posedge clk) disable iff (rst)
        (i_valid && clamp_en && fmt_code == 3'd1 && i_g >= FIX.lo && i_g <= FIX.hi) |=>
            (o_g == $past(i_g)));

    // R6: programmable bounds respected on red
    a_r6_prog_red: assert property (@(posedge clk) disable iff (rst)
        (i_valid && clamp_en && fmt_code == 3'd7 && bnd_q[0].lo <= bnd_q[0].hi) |=>
            (o_r >= $past(bnd_q[0].lo) && o_r <= $past(bnd_q[0].hi)));

    // R10: data holds while nothing is accepted
    a_r10_hold: assert property (@(posedge clk) disable iff (rst)
        !i_valid |=> ($stable(o_r) && $stable(o_g) && $stable(o_b)));

endmodule

// File: tb/tb_pix_range_clamp.sv
module tb_pix_range_clamp;

    logic        clk = 1'b0;
    logic        rst;
    logic        i_valid;
    logic [11:0] i_r, i_g, i_b;
    logic        clamp_en;
    logic [2:0]  fmt_code;
    logic        bnd_wr;
    logic [11:0] lo_r, hi_r, lo_g, hi_g, lo_b, hi_b;
    logic        o_valid;
    logic [11:0] o_r, o_g, o_b;

    int total = 0;
    int bad   = 0;

    // bench model of programmable bounds, index 0=R 1=G 2=B
    int mlo [3];
    int mhi [3];
    int last_r = 0, last_g = 0, last_b = 0;

    always #4 clk = ~clk;

    pix_range_clamp dut (
        .clk(clk), .rst(rst), .i_valid(i_valid),
        .i_r(i_r), .i_g(i_g), .i_b(i_b),
        .clamp_en(clamp_en), .fmt_code(fmt_code), .bnd_wr(bnd_wr),
        .lo_r(lo_r), .hi_r(hi_r), .lo_g(lo_g), .hi_g(hi_g), .lo_b(lo_b), .hi_b(hi_b),
        .o_valid(o_valid), .o_r(o_r), .o_g(o_g), .o_b(o_b)
    );

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int model(input int v, input int ch, input logic e, input int code);
        int lo, hi;
        if (!e) return v;
        if (code >= 1 && code <= 3) begin
            lo = 16 * 16; hi = 235 * 16;
        end else if (code == 7) begin
            lo = mlo[ch]; hi = mhi[ch];
        end else begin
            return v;
        end
        if (v < lo) return lo;
        if (v > hi) return hi;
        return v;
    endfunction

    function automatic string tag(input logic e, input int code);
        if (!e) return "R3";
        if (code >= 1 && code <= 3) return "R5/R9";
        if (code == 7) return "R6/R9";
        return "R4";
    endfunction

    task automatic px(input logic v, input int r, input int g, input int b,
                      input logic e, input int code);
        int er, eg, eb;
        @(negedge clk);
        i_valid  = v;
        i_r = 12'(r); i_g = 12'(g); i_b = 12'(b);
        clamp_en = e;
        fmt_code = 3'(code);
        @(posedge clk);
        #1;
        if (v) begin
            er = model(r, 0, e, code);
            eg = model(g, 1, e, code);
            eb = model(b, 2, e, code);
            chk("R2", int'(o_valid), 1);
            chk(tag(e, code), int'(o_r), er);
            chk(tag(e, code), int'(o_g), eg);
            chk(tag(e, code), int'(o_b), eb);
            last_r = er; last_g = eg; last_b = eb;
        end else begin
            chk("R2", int'(o_valid), 0);
            chk("R10", int'(o_r), last_r);
            chk("R10", int'(o_g), last_g);
            chk("R10", int'(o_b), last_b);
        end
    endtask

    task automatic load_bounds(input int lr, input int hr, input int lg,
                               input int hg, input int lb, input int hb);
        @(negedge clk);
        i_valid = 1'b0;
        bnd_wr = 1'b1;
        lo_r = 12'(lr); hi_r = 12'(hr);
        lo_g = 12'(lg); hi_g = 12'(hg);
        lo_b = 12'(lb); hi_b = 12'(hb);
        @(posedge clk);
        #1;
        mlo[0] = lr; mhi[0] = hr;
        mlo[1] = lg; mhi[1] = hg;
        mlo[2] = lb; mhi[2] = hb;
        @(negedge clk);
        bnd_wr = 1'b0;
        lo_r = '0; hi_r = '0; lo_g = '0; hi_g = '0; lo_b = '0; hi_b = '0;
    endtask

    task automatic sweep(input logic e, input int code);
        int edges [13] = '{0, 15, 16, 17, 255, 256, 257, 3759, 3760, 3761, 4078, 4079, 4095};
        for (int v = 0; v < 4096; v += 13)
            px(1'b1, v, 4095 - v, (v * 3) % 4096, e, code);
        for (int k = 0; k < 13; k++)
            px(1'b1, edges[k], edges[12 - k], edges[k], e, code);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        bad++;
        $display("FAIL watchdog: actual=expired expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        rst = 1'b1; i_valid = 1'b0; i_r = '0; i_g = '0; i_b = '0;
        clamp_en = 1'b0; fmt_code = '0; bnd_wr = 1'b0;
        lo_r = '0; hi_r = '0; lo_g = '0; hi_g = '0; lo_b = '0; hi_b = '0;
        for (int c = 0; c < 3; c++) begin mlo[c] = 16; mhi[c] = 4079; end
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        // R1: reset state
        chk("R1", int'(o_valid), 0);
        chk("R1", int'(o_r), 0);
        chk("R1", int'(o_g), 0);
        chk("R1", int'(o_b), 0);

        // R7: default programmable bounds
        px(1'b1, 0, 4095, 16, 1'b1, 7);
        chk("R7", int'(o_r), 16);
        chk("R7", int'(o_g), 4079);
        sweep(1'b1, 7);

        // R3, R4, R5: every code with enable off and on
        for (int code = 0; code < 8; code++) begin
            sweep(1'b0, code);
            sweep(1'b1, code);
        end

        // R10: hold with valid low, varied data
        px(1'b1, 100, 2000, 4000, 1'b1, 1);
        px(1'b0, 5, 6, 7, 1'b0, 0);
        px(1'b0, 4095, 0, 1234, 1'b1, 7);

        // R8: new bounds, distinct per channel, then sweep
        load_bounds(512, 768, 80, 3840, 2048, 2064);
        px(1'b1, 0, 0, 0, 1'b1, 7);
        chk("R8", int'(o_r), 512);
        chk("R8", int'(o_b), 2048);
        sweep(1'b1, 7);
        // narrow equal bounds
        load_bounds(1000, 1000, 0, 4095, 4095, 4095);
        sweep(1'b1, 7);
        // fixed codes unaffected by loaded bounds
        sweep(1'b1, 2);

        // R2: back-to-back valid then gap
        px(1'b1, 300, 300, 300, 1'b0, 0);
        px(1'b0, 1, 1, 1, 1'b0, 0);
        px(1'b1, 4000, 10, 2222, 1'b1, 3);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule